// File: doc/BRIEF.md
# Memory Low-Power Mode Controller

This block decides the low-power state of a self-refreshing memory. It watches an active-low sleep pin, the current value of the sleep bit in the configuration register, and a strobe that marks each software write to that register, along with the value of the sleep bit being written. A free-running tick input supplies the time base. From these it reports one of four modes: normal running, retention, full power-off, and wake-up. It also drives three enables to the rest of the memory: one that keeps the refresh engine on, one that gates read and write traffic, and one that says whether stored data can still be trusted.

The pin only counts as asleep once it has been held low for more than 10 µs. A qualified pin then selects retention (partial refresh) or full power-off, according to the register's sleep bit. Full power-off stops refresh and marks the data as lost. When the pin rises after power-off, the controller holds accesses off for a 150 µs wake-up period. Software can also request retention directly by writing the sleep bit as 1. After the first software write, the pin can no longer start retention. This lockout lasts until the next power-on reset. Software writes never lead to power-off.

All outputs are registered and change on the same clock edge as the mode. Both time windows are counted in tick pulses, and a parameter sets how many ticks make up one microsecond.

Top module: `lpm_ctrl`

## Requirements
- R1: The pin qualifies only on the tick that makes its continuous low time exceed QUAL_US*TICKS_PER_US ticks. A high level clears the count, so a shorter low pulse leaves the mode unchanged.
- R2: While running, a qualified pin moves the mode to retention (mode_o = 1) if cfg_sleep_i is 1 and no lockout is set. If cfg_sleep_i is 0, the mode moves to power-off (mode_o = 2). The mode codes are run = 0, retention = 1, power-off = 2 and wake-up = 3.
- R3: access_en_o is 0 whenever the mode is retention, power-off or wake-up.
- R4: Retention entered from the pin ends on the first clock edge that sees the pin high. mode_o returns to 0 and access_en_o returns to 1 on that edge.
- R5: In power-off, refresh_en_o is 0. data_valid_o drops to 0 on entry to power-off and stays 0 until power-on reset.
- R6: The first clock edge that sees the pin high in power-off enters wake-up (mode_o = 3). The mode returns to run on the WAKE_US*TICKS_PER_US-th tick after that edge.
- R7: While running, a software write with sw_sleep_i = 1 enters retention on that clock edge. Retention entered this way ignores the pin and ends only on a software write with sw_sleep_i = 0.
- R8: Any software write sets a lockout. Once it is set, a qualified pin with cfg_sleep_i = 1 leaves the mode at run. Only power-on reset clears the lockout.
- R9: A software write never moves the mode to power-off.
- R10: During and after power-on reset the mode is run, and refresh_en_o, access_en_o and data_valid_o are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Time-base pulse, TICKS_PER_US per microsecond |
| sleep_n_i | input | 1 | Active-low sleep pin |
| cfg_sleep_i | input | 1 | Current sleep bit of the configuration register |
| sw_wr_i | input | 1 | Software register write strobe |
| sw_sleep_i | input | 1 | Sleep bit value carried by the write |
| mode_o | output | 2 | 0 run, 1 retention, 2 power-off, 3 wake-up |
| refresh_en_o | output | 1 | Refresh engine enable |
| access_en_o | output | 1 | Read/write access enable |
| data_valid_o | output | 1 | Stored data still valid |

## Verification
The lockout is the hardest state to reach and observe from the ports, because it is invisible until a later pin qualification fails to act. The stimulus sets it with a harmless software write that clears the sleep bit. It then holds the pin low well past the window with cfg_sleep_i at 1 and checks that the mode stays at run. A power-on reset follows, and the same pin sequence is replayed to show that retention is entered again. The long wake-up window is checked on both sides of its end: once shortly before the final tick, and again after it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_RETAIN = 2'd1,
    MODE_OFF    = 2'd2,
    MODE_WAKE   = 2'd3
  } lpm_mode_t;
endpackage

// File: rtl/lpm_pin_qual.sv
module lpm_pin_qual #(
  parameter int QUAL_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic sleep_n_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_TICKS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || sleep_n_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q <= LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = (cnt_q > LIMIT);

  // R1: a high pin always drops qualification on the next edge
  p_release_clears_r1: assert property (@(posedge clk) disable iff (rst)
    sleep_n_i |=> !qual_o);

  // R1: qualification only appears on a tick while the pin is low
  p_qual_on_low_tick_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> $past(!sleep_n_i && tick_i));
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int WAKE_TICKS = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(WAKE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  // R6: the count never passes the last tick of the window
  p_wake_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_n_i,
  input  logic      qual_i,
  input  logic      cfg_sleep_i,
  input  logic      sw_wr_i,
  input  logic      sw_sleep_i,
  input  logic      wake_done_i,
  output logic      wake_clear_o,
  output logic      wake_run_o,
  output lpm_mode_t mode_o,
  output logic      refresh_en_o,
  output logic      access_en_o,
  output logic      data_valid_o
);
  lpm_mode_t state_q, state_d;
  logic      bysw_q, bysw_d;
  logic      lock_q;

  always_comb begin
    state_d = state_q;
    bysw_d  = bysw_q;
    unique case (state_q)
      MODE_RUN: begin
        if (sw_wr_i && sw_sleep_i) begin
          state_d = MODE_RETAIN;
          bysw_d  = 1'b1;
        end else if (qual_i) begin
          if (!cfg_sleep_i) begin
            state_d = MODE_OFF;
          end else if (!lock_q) begin
            state_d = MODE_RETAIN;
            bysw_d  = 1'b0;
          end
        end
      end
      MODE_RETAIN: begin
        if (bysw_q ? (sw_wr_i && !sw_sleep_i) : sleep_n_i) begin
          state_d = MODE_RUN;
        end
      end
      MODE_OFF:  if (sleep_n_i)   state_d = MODE_WAKE;
      MODE_WAKE: if (wake_done_i) state_d = MODE_RUN;
      default:   state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= MODE_RUN;
      bysw_q       <= 1'b0;
      lock_q       <= 1'b0;
      refresh_en_o <= 1'b1;
      access_en_o  <= 1'b1;
      data_valid_o <= 1'b1;
    end else begin
      state_q      <= state_d;
      bysw_q       <= bysw_d;
      lock_q       <= lock_q | sw_wr_i;
      refresh_en_o <= (state_d != MODE_OFF);
      access_en_o  <= (state_d == MODE_RUN);
      if (state_d == MODE_OFF) data_valid_o <= 1'b0;
    end
  end

  assign mode_o       = state_q;
  assign wake_clear_o = (state_q == MODE_OFF);
  assign wake_run_o   = (state_q == MODE_WAKE);

  p_off_no_refresh_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_OFF) |-> !refresh_en_o);

  p_off_data_lost_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_OFF) |-> !data_valid_o);

  p_lowpower_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q != MODE_RUN) |-> !access_en_o);

  p_pin_release_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_RETAIN && !bysw_q && sleep_n_i)
      |=> (state_q == MODE_RUN && access_en_o));

  p_off_to_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_OFF && sleep_n_i) |=> (state_q == MODE_WAKE));

  p_sw_enter_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_RUN && sw_wr_i && sw_sleep_i) |=> (state_q == MODE_RETAIN));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  p_sw_not_off_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_RUN && sw_wr_i && !qual_i) |=> (state_q != MODE_OFF));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TICKS_PER_US = 2,
  parameter int QUAL_US      = 10,
  parameter int WAKE_US      = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       sleep_n_i,
  input  logic       cfg_sleep_i,
  input  logic       sw_wr_i,
  input  logic       sw_sleep_i,
  output logic [1:0] mode_o,
  output logic       refresh_en_o,
  output logic       access_en_o,
  output logic       data_valid_o
);
  localparam int QUAL_TICKS = QUAL_US * TICKS_PER_US;
  localparam int WAKE_TICKS = WAKE_US * TICKS_PER_US;

  logic      qual;
  logic      wake_done, wake_clear, wake_run;
  lpm_mode_t mode;

  lpm_pin_qual #(.QUAL_TICKS(QUAL_TICKS)) qual_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sleep_n_i(sleep_n_i), .qual_o(qual)
  );

  lpm_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) wake_i (
    .clk(clk), .rst(rst), .clear_i(wake_clear), .run_i(wake_run),
    .tick_i(tick_i), .done_o(wake_done)
  );

  lpm_mode_fsm fsm_i (
    .clk(clk), .rst(rst), .sleep_n_i(sleep_n_i), .qual_i(qual),
    .cfg_sleep_i(cfg_sleep_i), .sw_wr_i(sw_wr_i), .sw_sleep_i(sw_sleep_i),
    .wake_done_i(wake_done), .wake_clear_o(wake_clear), .wake_run_o(wake_run),
    .mode_o(mode), .refresh_en_o(refresh_en_o), .access_en_o(access_en_o),
    .data_valid_o(data_valid_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb_top;
  localparam int TPU = 2;
  localparam int QT = 10 * TPU;
  localparam int WT = 150 * TPU;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic sleep_n_i = 1'b1, cfg_sleep_i = 1'b0, sw_wr_i = 1'b0, sw_sleep_i = 1'b0;
  logic [1:0] mode_o;
  logic refresh_en_o, access_en_o, data_valid_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R10";

  always #4 clk = ~clk;

  lpm_ctrl #(.TICKS_PER_US(TPU), .QUAL_US(10), .WAKE_US(150)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sleep_n_i(sleep_n_i),
    .cfg_sleep_i(cfg_sleep_i), .sw_wr_i(sw_wr_i), .sw_sleep_i(sw_sleep_i),
    .mode_o(mode_o), .refresh_en_o(refresh_en_o), .access_en_o(access_en_o),
    .data_valid_o(data_valid_o)
  );

  int div_cnt = 0;
  always @(negedge clk) begin
    div_cnt = (div_cnt + 1) % DIV;
    tick_i <= (div_cnt == 0);
  end

  // behavioural reference
  int m_mode = 0, m_low = 0, m_wake = 0;
  bit m_lock = 0, m_sw = 0, m_dv = 1;
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_low = 0; m_wake = 0; m_lock = 0; m_sw = 0; m_dv = 1;
    end else begin
      bit q;
      q = (m_low > QT);
      if (sleep_n_i) m_low = 0;
      else if (tick_i && m_low <= QT) m_low++;
      case (m_mode)
        0: if (sw_wr_i && sw_sleep_i) begin m_mode = 1; m_sw = 1; end
           else if (q && !cfg_sleep_i) m_mode = 2;
           else if (q && !m_lock) begin m_mode = 1; m_sw = 0; end
        1: if (m_sw ? (sw_wr_i && !sw_sleep_i) : sleep_n_i) m_mode = 0;
        2: if (sleep_n_i) begin m_mode = 3; m_wake = 0; end
        default: if (tick_i) begin
             m_wake++;
             if (m_wake == WT) m_mode = 0;
           end
      endcase
      if (m_mode == 2) m_dv = 0;
      if (sw_wr_i) m_lock = 1;
    end
    #2;
    checks++;
    if (mode_o !== 2'(m_mode) || refresh_en_o !== (m_mode != 2) ||
        access_en_o !== (m_mode == 0) || data_valid_o !== m_dv) begin
      errors++;
      $display("FAIL %s model: mode=%0d ref=%0b acc=%0b dv=%0b exp mode=%0d ref=%0b acc=%0b dv=%0b",
               phase, mode_o, refresh_en_o, access_en_o, data_valid_o,
               m_mode, (m_mode != 2), (m_mode == 0), m_dv);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_write(bit v);
    sw_wr_i = 1'b1; sw_sleep_i = v;
    @(negedge clk);
    sw_wr_i = 1'b0; sw_sleep_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 mode", mode_o, 0);
    chk("R10 refresh", refresh_en_o, 1);
    chk("R10 access", access_en_o, 1);
    chk("R10 valid", data_valid_o, 1);

    phase = "R1"; cfg_sleep_i = 1'b1;
    sleep_n_i = 1'b0; ticks(QT - 2); sleep_n_i = 1'b1; ticks(2);
    sleep_n_i = 1'b0; ticks(QT - 2); sleep_n_i = 1'b1; ticks(2);
    chk("R1 short pulses", mode_o, 0);

    phase = "R2";
    sleep_n_i = 1'b0; ticks(QT + 5);
    chk("R2 retention", mode_o, 1);
    chk("R3 retention access", access_en_o, 0);
    phase = "R4";
    sleep_n_i = 1'b1; @(negedge clk);
    chk("R4 exit mode", mode_o, 0);
    chk("R4 exit access", access_en_o, 1);

    phase = "R5"; cfg_sleep_i = 1'b0;
    sleep_n_i = 1'b0; ticks(QT + 5);
    chk("R2 power-off", mode_o, 2);
    chk("R5 refresh", refresh_en_o, 0);
    chk("R5 valid", data_valid_o, 0);
    chk("R3 off access", access_en_o, 0);
    phase = "R6";
    sleep_n_i = 1'b1; @(negedge clk);
    chk("R6 wake", mode_o, 3);
    chk("R3 wake access", access_en_o, 0);
    ticks(WT - 3);
    chk("R6 still waking", mode_o, 3);
    ticks(5);
    chk("R6 back to run", mode_o, 0);
    chk("R5 valid stays low", data_valid_o, 0);

    phase = "R7"; por();
    cfg_sleep_i = 1'b0;
    sw_write(1'b1);
    chk("R7 sw retention", mode_o, 1);
    ticks(QT + 5);
    chk("R7 pin ignored", mode_o, 1);
    sw_write(1'b0);
    chk("R7 sw exit", mode_o, 0);

    phase = "R9";
    repeat (4) sw_write(1'b0);
    chk("R9 no power-off", mode_o, 0);

    phase = "R8"; cfg_sleep_i = 1'b1;
    sleep_n_i = 1'b0; ticks(QT + 5);
    chk("R8 lockout", mode_o, 0);
    chk("R8 lockout access", access_en_o, 1);
    sleep_n_i = 1'b1; ticks(2);
    por();
    phase = "R8";
    sleep_n_i = 1'b0; ticks(QT + 5);
    chk("R8 lockout cleared", mode_o, 1);
    sleep_n_i = 1'b1; ticks(2);
    chk("R4 final exit", mode_o, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule